// File: doc/BRIEF.md
# Caching-Bridge Snoop Filter

This block sits in the memory controller and remembers which cache lines are held in the prefetch buffers of three caching bridges on a shared I/O bus. Fill and eviction notices from the bridges keep it current. Each tracked line has a tag and a three-bit presence vector, with one bit per bridge.

A processor request that intends to modify a line is looked up in the filter. On a hit, exactly one invalidate command goes out on the I/O bus. It carries the line address and the presence vector, so only the holding bridges act on it. On a miss, and for any plain read, the bus sees nothing.

The store is set-associative, with 64 sets of 4 ways. A fill into a full set replaces the least recently filled way. It first sends a back-invalidate for the line it displaces, so the filter never under-reports. The invalidate output uses a valid/ready handshake, and an entry's bits are cleared only when its invalidate is taken.

Top module: `snoop_filter`

## Requirements
- R1: After reset no line is tracked, `inv_valid` is 0, and both `fill_ready` and `req_ready` are 1.
- R2: An intent-to-modify request (`req_modify`=1) that hits produces one invalidate on the cycle after acceptance. It carries `inv_line` equal to the requested line and `inv_mask` with bit i set for each bridge i holding it.
- R3: An intent-to-modify request that misses produces no invalidate.
- R4: A read request (`req_modify`=0) is always accepted. It never produces an invalidate and leaves the tracked state unchanged.
- R5: While `inv_valid`=1 and `inv_ready`=0, the command holds steady and intent-to-modify requests see `req_ready`=0. When the handshake completes, the bits named in `inv_mask` are cleared from that line, so a repeated request for it misses.
- R6: An eviction notice clears only the named bridge's bit for that line. A line with no bits left is no longer tracked.
- R7: A fill that misses in a full set displaces the way filled least recently. It sends a back-invalidate carrying that way's line and presence vector.
- R8: A fill and an intent-to-modify request to the same line in the same cycle are ordered fill first. The invalidate includes the filling bridge.
- R9: A fill that would need a back-invalidate while one is pending sees `fill_ready`=0. After the pending handshake, it reuses any way that the handshake freed, without a back-invalidate.
- R10: Fills of the same line by several bridges accumulate in one entry's presence vector, and a repeat fill allocates no new way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Bridge has loaded a line |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_bridge | input | 2 | Index of the filling bridge (0..2) |
| fill_line | input | 26 | Line address of the fill (low 6 bits select the set) |
| evict_valid | input | 1 | Bridge has dropped a line |
| evict_bridge | input | 2 | Index of the evicting bridge |
| evict_line | input | 26 | Line address dropped |
| req_valid | input | 1 | Processor request present |
| req_modify | input | 1 | 1 = intent to modify, 0 = read |
| req_line | input | 26 | Requested line address |
| req_ready | output | 1 | Request accepted this cycle |
| inv_valid | output | 1 | Invalidate command pending |
| inv_ready | input | 1 | I/O bus takes the command |
| inv_line | output | 26 | Line to invalidate |
| inv_mask | output | 3 | Bridges that must drop the line |

## Verification
A bridge fill and an intent-to-modify lookup can land in the same cycle. The bench drives both to one line at once, on a line first held by nobody and then on one already held by another bridge. It judges the ordering by the invalidate mask, which must already contain the filling bridge. A second collision pits a fill needing a victim against a pending invalidate. That case is judged by `fill_ready` staying low and by the absence of any back-invalidate once the handshake frees a way.

// File: rtl/snoop_filter.sv
module snoop_filter #(
  parameter int LINE_W = 26,
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int NBR    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fill_valid,
  output logic                      fill_ready,
  input  logic [$clog2(NBR)-1:0]    fill_bridge,
  input  logic [LINE_W-1:0]         fill_line,
  input  logic                      evict_valid,
  input  logic [$clog2(NBR)-1:0]    evict_bridge,
  input  logic [LINE_W-1:0]         evict_line,
  input  logic                      req_valid,
  input  logic                      req_modify,
  input  logic [LINE_W-1:0]         req_line,
  output logic                      req_ready,
  output logic                      inv_valid,
  input  logic                      inv_ready,
  output logic [LINE_W-1:0]         inv_line,
  output logic [NBR-1:0]            inv_mask
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = LINE_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [NBR-1:0]   pres_q [SETS][WAYS];
  logic [NBR-1:0]   pres_n [SETS][WAYS];
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_n  [SETS][WAYS];
  logic [WAY_W-1:0] age_q  [SETS][WAYS];

  wire [SET_W-1:0] f_set  = fill_line[SET_W-1:0];
  wire [TAG_W-1:0] f_tag  = fill_line[LINE_W-1:SET_W];
  wire [SET_W-1:0] e_set  = evict_line[SET_W-1:0];
  wire [TAG_W-1:0] e_tag  = evict_line[LINE_W-1:SET_W];
  wire [SET_W-1:0] r_set  = req_line[SET_W-1:0];
  wire [TAG_W-1:0] r_tag  = req_line[LINE_W-1:SET_W];
  wire [SET_W-1:0] i_set  = inv_line[SET_W-1:0];
  wire [TAG_W-1:0] i_tag  = inv_line[LINE_W-1:SET_W];
  wire [NBR-1:0]   f_bit  = NBR'(1) << fill_bridge;
  wire [NBR-1:0]   e_bit  = NBR'(1) << evict_bridge;

  logic             f_hit, f_has_free;
  logic [WAY_W-1:0] f_hway, f_free_way, f_lru_way, f_way;

  always_comb begin
    f_hit = 1'b0; f_has_free = 1'b0;
    f_hway = '0; f_free_way = '0; f_lru_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (pres_q[f_set][w] == '0) begin
        f_has_free = 1'b1;
        f_free_way = WAY_W'(w);
      end else if (tag_q[f_set][w] == f_tag) begin
        f_hit  = 1'b1;
        f_hway = WAY_W'(w);
      end
      if (age_q[f_set][w] == WAY_W'(WAYS-1)) f_lru_way = WAY_W'(w);
    end
    f_way = f_hit ? f_hway : (f_has_free ? f_free_way : f_lru_way);
  end

  wire f_need_vic = !f_hit && !f_has_free;
  assign fill_ready = !(f_need_vic && inv_valid);
  wire fill_do  = fill_valid && fill_ready;
  wire vic_take = fill_do && f_need_vic;
  wire inv_fire = inv_valid && inv_ready;

  always_comb begin
    logic [NBR-1:0]   p;
    logic [TAG_W-1:0] t;
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        p = pres_q[s][w];
        t = tag_q[s][w];
        if (inv_fire && i_set == SET_W'(s) && t == i_tag) p = p & ~inv_mask;
        if (evict_valid && e_set == SET_W'(s) && t == e_tag) p = p & ~e_bit;
        if (fill_do && f_set == SET_W'(s) && f_way == WAY_W'(w)) begin
          if (!f_hit) begin
            t = f_tag;
            p = '0;
          end
          p = p | f_bit;
        end
        pres_n[s][w] = p;
        tag_n[s][w]  = t;
      end
    end
  end

  logic           r_hit;
  logic [NBR-1:0] r_mask;

  always_comb begin
    r_hit = 1'b0; r_mask = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (pres_n[r_set][w] != '0 && tag_n[r_set][w] == r_tag) begin
        r_hit  = 1'b1;
        r_mask = r_mask | pres_n[r_set][w];
      end
    end
  end

  assign req_ready = !req_modify || (!inv_valid && !vic_take);
  wire rfo_do = req_valid && req_modify && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_valid <= 1'b0;
      inv_line  <= '0;
      inv_mask  <= '0;
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          pres_q[s][w] <= '0;
          tag_q[s][w]  <= '0;
          age_q[s][w]  <= WAY_W'(w);
        end
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          pres_q[s][w] <= pres_n[s][w];
          tag_q[s][w]  <= tag_n[s][w];
        end
      end
      if (fill_do) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == f_way)
            age_q[f_set][w] <= '0;
          else if (age_q[f_set][w] < age_q[f_set][f_way])
            age_q[f_set][w] <= age_q[f_set][w] + 1'b1;
        end
      end
      if (vic_take) begin
        inv_valid <= 1'b1;
        inv_line  <= {tag_q[f_set][f_way], f_set};
        inv_mask  <= pres_q[f_set][f_way];
      end else if (rfo_do && r_hit) begin
        inv_valid <= 1'b1;
        inv_line  <= req_line;
        inv_mask  <= r_mask;
      end else if (inv_fire) begin
        inv_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
  parameter int LINE_W = 26,
  parameter int NBR    = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fill_valid,
  input logic                   fill_ready,
  input logic                   req_valid,
  input logic                   req_modify,
  input logic                   req_ready,
  input logic                   inv_valid,
  input logic                   inv_ready,
  input logic [LINE_W-1:0]      inv_line,
  input logic [NBR-1:0]         inv_mask
);
  a_r5_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_line) && $stable(inv_mask));

  a_r5_modify_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && req_modify |-> !req_ready);

  a_r4_read_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    !req_modify |-> req_ready);

  a_r2_mask_names_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_mask != '0);

  a_r3_no_cause_no_command: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_valid && !fill_valid && !(req_valid && req_modify) |=> !inv_valid);

  a_r9_fill_open_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_valid |-> fill_ready);
endmodule

bind snoop_filter sf_checker #(.LINE_W(LINE_W), .NBR(NBR)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .req_valid(req_valid), .req_modify(req_modify), .req_ready(req_ready),
  .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_line(inv_line), .inv_mask(inv_mask)
);

// File: tb/sim_snoop_filter.sv
`timescale 1ns/100ps
module sim_snoop_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_valid = 1'b0, evict_valid = 1'b0, req_valid = 1'b0, req_modify = 1'b0;
  logic        inv_ready = 1'b1;
  logic [1:0]  fill_bridge = '0, evict_bridge = '0;
  logic [25:0] fill_line = '0, evict_line = '0, req_line = '0;
  logic        fill_ready, req_ready, inv_valid;
  logic [25:0] inv_line;
  logic [2:0]  inv_mask;

  int total = 0;
  int bad = 0;
  logic [28:0] exp_q[$];

  always #2.5 clk = ~clk;

  snoop_filter u0 (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_bridge(fill_bridge), .fill_line(fill_line),
    .evict_valid(evict_valid), .evict_bridge(evict_bridge), .evict_line(evict_line),
    .req_valid(req_valid), .req_modify(req_modify), .req_line(req_line), .req_ready(req_ready),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_line(inv_line), .inv_mask(inv_mask)
  );

  function automatic logic [25:0] ln(int t, int s);
    return {20'(t), 6'(s)};
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && inv_valid && inv_ready) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected invalidate: actual=%0h expected=none", {inv_line, inv_mask});
      end else begin
        logic [28:0] e;
        e = exp_q.pop_front();
        if ({inv_line, inv_mask} != e) begin
          bad++;
          $display("FAIL R2 invalidate line/mask: actual=%0h expected=%0h", {inv_line, inv_mask}, e);
        end
      end
    end
  end

  task automatic fill(int b, logic [25:0] a);
    fill_valid = 1'b1; fill_bridge = 2'(b); fill_line = a;
    #0.5;
    while (!fill_ready) begin cyc(); #0.5; end
    cyc();
    fill_valid = 1'b0;
  endtask

  task automatic evict(int b, logic [25:0] a);
    evict_valid = 1'b1; evict_bridge = 2'(b); evict_line = a;
    cyc();
    evict_valid = 1'b0;
  endtask

  task automatic rfo(logic [25:0] a, bit hit, logic [2:0] m);
    req_valid = 1'b1; req_modify = 1'b1; req_line = a;
    #0.5;
    while (!req_ready) begin cyc(); #0.5; end
    if (hit) exp_q.push_back({a, m});
    cyc();
    req_valid = 1'b0;
    cyc(); cyc();
  endtask

  task automatic rd(logic [25:0] a);
    req_valid = 1'b1; req_modify = 1'b0; req_line = a;
    #0.5;
    chk(req_ready, "R4", "read accepted", req_ready, 1);
    cyc();
    req_valid = 1'b0;
    cyc(); cyc();
  endtask

  task automatic both(int b, logic [25:0] a, logic [2:0] m);
    fill_valid = 1'b1; fill_bridge = 2'(b); fill_line = a;
    req_valid = 1'b1; req_modify = 1'b1; req_line = a;
    #0.5;
    chk(fill_ready && req_ready, "R8", "fill and request taken together", {fill_ready, req_ready}, 3);
    exp_q.push_back({a, m});
    cyc();
    fill_valid = 1'b0; req_valid = 1'b0;
    cyc(); cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    #0.5;
    chk(!inv_valid, "R1", "inv_valid after reset", inv_valid, 0);
    chk(fill_ready, "R1", "fill_ready after reset", fill_ready, 1);
    chk(req_ready, "R1", "req_ready after reset", req_ready, 1);
    rfo(ln(1, 0), 0, 3'b000);                 // R1/R3: empty filter misses

    fill(0, ln(7, 1)); fill(2, ln(7, 1));     // R10: two bridges share one entry
    rfo(ln(7, 1), 1, 3'b101);                 // R2
    rfo(ln(7, 1), 0, 3'b000);                 // R5: cleared after handshake
    rfo(ln(99, 1), 0, 3'b000);                // R3: miss

    fill(1, ln(8, 2));
    rd(ln(8, 2));                             // R4: read, no command
    rfo(ln(8, 2), 1, 3'b010);                 // R4: state untouched

    fill(0, ln(9, 3)); fill(1, ln(9, 3));
    evict(0, ln(9, 3));                       // R6: only bridge 0 cleared
    rfo(ln(9, 3), 1, 3'b010);
    fill(2, ln(10, 3));
    evict(2, ln(10, 3));                      // R6: last bit gone
    evict(1, ln(11, 3));                      // R6: absent line, no effect
    rfo(ln(10, 3), 0, 3'b000);

    fill(0, ln(1, 5)); fill(1, ln(2, 5)); fill(0, ln(3, 5)); fill(0, ln(4, 5));
    fill(2, ln(1, 5));                        // R10: hit, no allocation
    exp_q.push_back({ln(2, 5), 3'b010});      // R7: way of line 2 is least recent
    fill(1, ln(5, 5));
    cyc(); cyc();
    rfo(ln(2, 5), 0, 3'b000);                 // R7: victim no longer tracked

    inv_ready = 1'b0;                         // R9: victim needed while pending
    req_valid = 1'b1; req_modify = 1'b1; req_line = ln(3, 5);
    #0.5;
    exp_q.push_back({ln(3, 5), 3'b001});
    cyc();
    req_valid = 1'b0;
    fill_valid = 1'b1; fill_bridge = 2'd2; fill_line = ln(6, 5);
    #0.5;
    chk(!fill_ready, "R9", "fill blocked while pending", fill_ready, 0);
    cyc(); #0.5;
    chk(!fill_ready, "R9", "fill still blocked", fill_ready, 0);
    inv_ready = 1'b1;
    while (!fill_ready) begin cyc(); #0.5; end
    cyc();
    fill_valid = 1'b0;
    cyc(); cyc();                             // R9: no back-invalidate expected
    rfo(ln(6, 5), 1, 3'b100);
    rfo(ln(5, 5), 1, 3'b010);
    rfo(ln(1, 5), 1, 3'b101);
    rfo(ln(4, 5), 1, 3'b001);

    both(2, ln(12, 6), 3'b100);               // R8: fill ordered first
    fill(0, ln(13, 6));
    both(1, ln(13, 6), 3'b011);               // R8

    fill(0, ln(14, 7)); fill(1, ln(15, 7));
    inv_ready = 1'b0;
    req_valid = 1'b1; req_modify = 1'b1; req_line = ln(14, 7);
    #0.5;
    exp_q.push_back({ln(14, 7), 3'b001});
    cyc();
    req_line = ln(15, 7);
    for (int i = 0; i < 3; i++) begin
      #0.5;
      chk(!req_ready, "R5", "request held off while stalled", req_ready, 0);
      chk(inv_valid && inv_line == ln(14, 7) && inv_mask == 3'b001, "R5", "stalled command steady",
          {inv_valid, inv_line, inv_mask}, {1'b1, ln(14, 7), 3'b001});
      cyc();
    end
    inv_ready = 1'b1;
    #0.5;
    while (!req_ready) begin cyc(); #0.5; end
    exp_q.push_back({ln(15, 7), 3'b010});
    cyc();
    req_valid = 1'b0;
    cyc(); cyc();
    rfo(ln(14, 7), 0, 3'b000);                // R5: cleared after release

    repeat (5) cyc();
    chk(exp_q.size() == 0, "R2", "all expected invalidates seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule